// File: doc/BRIEF.md
# PCIe BAR Set Hit Decoder

This block holds the six base address registers of one PCIe function and decides which of them, if any, claims an incoming request. Each BAR has a fixed shape, set by parameters: whether it exists, whether it maps memory or I/O space, whether it is 32-bit or 64-bit, whether it is prefetchable, and its power-of-two size. A 64-bit memory BAR takes the next index as its upper address word. The shape rules differ between a legacy endpoint and a non-legacy endpoint. Any BAR whose shape breaks a rule is flagged on a constant legality output and is then treated as absent.

Configuration software reaches the BAR words through a small indexed read/write port. Writing all ones and reading back returns the size mask with the type bits, which is the usual sizing probe. The request side takes an address, a space type and an address width. One clock later it reports whether the request hit a BAR and, if so, the lowest matching BAR index.

Top module: `bar_hit_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `hit_valid`, `hit`, `hit_bar` and `cfg_rdata` are zero, and every stored BAR word is zero.
- R2: When a memory BAR at index k is 64-bit, BAR k+1 holds bits 63:32 of its base. BAR k+1 reads back exactly the bits written to it (bits below log2(size)-32 fixed at zero), takes no attribute bits, and never produces a hit of its own. A 64-bit setting on the last BAR is illegal.
- R3: An I/O BAR is illegal when the function is not a legacy endpoint, when it is 64-bit, or when it is prefetchable.
- R4: Sizes are 2^n bytes. The legal n is 7..31 for a 32-bit memory BAR and 7..63 for a 64-bit memory BAR in non-legacy mode. In legacy mode the lower limit is 4. For an I/O BAR the legal n is 4..31.
- R5: In non-legacy mode, a prefetchable 32-bit memory BAR at any index except the last (BAR5) is illegal. Legacy mode allows it.
- R6: A BAR that is disabled or illegal sets its bit in `bar_illegal` (illegal only), reads back as zero, ignores writes and never hits.
- R7: The writable bits of a lower BAR word are those at or above log2(size). In the read value, a memory BAR shows bit 0 = 0, bits 2:1 = 10 if 64-bit and 00 if 32-bit, and bit 3 = prefetchable. An I/O BAR shows bit 0 = 1 and bit 1 = 0. A BAR word changes only when it is written.
- R8: A BAR hits when the request address, masked to bits at or above log2(size), equals the programmed base over 64 bits. For a 32-bit BAR the upper base word is zero. When `req_is64` is 0, bits 63:32 of `req_addr` are treated as zero.
- R9: A memory BAR only matches requests with `req_is_io`=0, and an I/O BAR only matches requests with `req_is_io`=1.
- R10: Memory BARs match only while `mem_en`=1, and I/O BARs only while `io_en`=1.
- R11: When several BARs match, `hit_bar` reports the lowest index.
- R12: `hit_valid`, `hit` and `hit_bar` register one clock after the request cycle, and `hit_bar` is zero without a hit. `cfg_rdata` registers one clock after a `cfg_rd` cycle and holds otherwise. An index above 5 reads zero. A decode in the same cycle as a write uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Memory decoding enable |
| io_en | input | 1 | I/O decoding enable |
| cfg_we | input | 1 | Write strobe for BAR word `cfg_idx` |
| cfg_rd | input | 1 | Read strobe for BAR word `cfg_idx` |
| cfg_idx | input | 3 | BAR word index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is64 | input | 1 | 1 = 64-bit address, 0 = 32-bit address |
| hit_valid | output | 1 | Decode result valid |
| hit | output | 1 | A BAR claimed the request |
| hit_bar | output | 3 | Index of the claiming BAR |
| bar_illegal | output | 6 | Per-BAR illegal-configuration flags |

## Verification
The assertions check on every cycle that any hit lands on an active lower BAR and never on an upper word. They also check that the hit's space type and enable match the request one cycle earlier, that no lower-indexed BAR also matched, and that a result only follows a request. They also check that BAR words stay stable without a write. Only the bench scenarios can show the legality flags for both endpoint modes, the sizing-probe values, the 64-bit base compare including the upper word, the overlap priority between two BARs, and that writes to disabled BARs have no effect. The bench runs a non-legacy and a legacy instance side by side against a behavioural model.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

  localparam int unsigned MAX_BARS = 32;
  localparam int unsigned SZ_W     = 7;

  // Slots that serve as the upper word of a 64-bit memory BAR below them
  function automatic logic [MAX_BARS-1:0] upper_slots(int unsigned n,
      logic [MAX_BARS-1:0] en, logic [MAX_BARS-1:0] io, logic [MAX_BARS-1:0] b64);
    logic [MAX_BARS-1:0] up;
    up = '0;
    for (int k = 0; k < MAX_BARS - 1; k++) begin
      if ((k + 1 < n) && !up[k] && en[k] && b64[k] && !io[k]) up[k+1] = 1'b1;
    end
    return up;
  endfunction

  // Shape legality for one lower slot
  function automatic logic slot_bad(int unsigned k, int unsigned n, logic legacy,
      logic io, logic b64, logic pf, int unsigned lg);
    int unsigned lo_lim;
    if (io) return !legacy || b64 || pf || (lg < 4) || (lg > 31);
    lo_lim = legacy ? 4 : 7;
    if (b64 && (k == n - 1)) return 1'b1;
    if (pf && !b64 && !legacy && (k != n - 1)) return 1'b1;
    if (lg < lo_lim) return 1'b1;
    if (lg > (b64 ? 63 : 31)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] lo_wmask(int unsigned lg);
    if (lg >= 32) return '0;
    return ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [31:0] hi_wmask(int unsigned lg);
    if (lg <= 32) return '1;
    return ~((32'd1 << (lg - 32)) - 32'd1);
  endfunction

  function automatic logic [31:0] attr_bits(logic io, logic b64, logic pf);
    if (io) return 32'h1;
    return {28'd0, pf, b64, 2'b00};
  endfunction

endpackage

// File: rtl/bar_word_reg.sv
module bar_word_reg #(
  parameter bit          ACTIVE = 1'b1,
  parameter logic [31:0] WMASK  = 32'hFFFF_FFFF,
  parameter logic [31:0] ATTR   = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] q,
  output logic [31:0] rd
);

  if (ACTIVE) begin : g_on
    logic [31:0] q_r;

    always_ff @(posedge clk) begin
      if (rst)     q_r <= '0;
      else if (we) q_r <= wdata & WMASK;
    end

    assign q  = q_r;
    assign rd = q_r | ATTR;

    // R7: the stored base only moves on a write
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q_r));
  end else begin : g_off
    assign q  = '0;
    assign rd = '0;
  end

endmodule

// File: rtl/bar_match.sv
module bar_match #(
  parameter bit          IS_IO = 1'b0,
  parameter int unsigned LG    = 12
) (
  input  logic [31:0] base_lo,
  input  logic [31:0] base_hi,
  input  logic [63:0] addr,
  input  logic        req_is_io,
  input  logic        mem_en,
  input  logic        io_en,
  output logic        match
);

  localparam logic [63:0] MASK = ~((64'd1 << LG) - 64'd1);

  logic space_ok;

  always_comb begin
    space_ok = IS_IO ? (req_is_io && io_en) : (!req_is_io && mem_en);
    match    = space_ok && ((addr & MASK) == {base_hi, base_lo});
  end

endmodule

// File: rtl/bar_prio.sv
module bar_prio #(
  parameter int unsigned N  = 6,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end

endmodule

// File: rtl/bar_hit_decoder.sv
module bar_hit_decoder
  import bar_dec_pkg::*;
#(
  parameter int unsigned N_BAR    = 6,
  parameter bit          LEGACY   = 1'b0,
  parameter logic [N_BAR-1:0] BAR_EN = 6'b111101,
  parameter logic [N_BAR-1:0] BAR_IO = 6'b010000,
  parameter logic [N_BAR-1:0] BAR_64 = 6'b000001,
  parameter logic [N_BAR-1:0] BAR_PF = 6'b100101,
  parameter logic [N_BAR*SZ_W-1:0] BAR_LOG2 =
    {7'd7, 7'd4, 7'd4, 7'd12, 7'd0, 7'd20},
  localparam int unsigned IW = $clog2(N_BAR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_en,
  input  logic             io_en,
  input  logic             cfg_we,
  input  logic             cfg_rd,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic [63:0]      req_addr,
  input  logic             req_is_io,
  input  logic             req_is64,
  output logic             hit_valid,
  output logic             hit,
  output logic [IW-1:0]    hit_bar,
  output logic [N_BAR-1:0] bar_illegal
);

  localparam logic [MAX_BARS-1:0] UP_ALL = upper_slots(N_BAR,
    MAX_BARS'(BAR_EN), MAX_BARS'(BAR_IO), MAX_BARS'(BAR_64));

  logic [31:0]      word_q [N_BAR];
  logic [31:0]      word_rd[N_BAR];
  logic [N_BAR-1:0] match_v;
  logic [N_BAR-1:0] act_v;
  logic [N_BAR-1:0] up_v;
  logic [63:0]      addr_eff;
  logic             any_m;
  logic [IW-1:0]    win_idx;

  assign addr_eff = req_is64 ? req_addr : {32'd0, req_addr[31:0]};

  for (genvar i = 0; i < N_BAR; i++) begin : g_bar
    localparam int unsigned JI = (i > 0) ? i - 1 : 0;
    localparam int unsigned KI = (i < N_BAR - 1) ? i + 1 : i;
    localparam int unsigned LG = int'(BAR_LOG2[i*SZ_W +: SZ_W]);
    localparam int unsigned JL = int'(BAR_LOG2[JI*SZ_W +: SZ_W]);
    localparam bit IS_UP = UP_ALL[i];
    localparam bit BAD   = BAR_EN[i] && !IS_UP &&
      slot_bad(i, N_BAR, LEGACY, BAR_IO[i], BAR_64[i], BAR_PF[i], LG);
    localparam bit ACT   = BAR_EN[i] && !IS_UP && !BAD;
    localparam bit LOW_ACT = (i > 0) && BAR_EN[JI] && !UP_ALL[JI] &&
      !slot_bad(JI, N_BAR, LEGACY, BAR_IO[JI], BAR_64[JI], BAR_PF[JI], JL);
    localparam bit UP_ACT = IS_UP && LOW_ACT;
    localparam logic [31:0] WM = IS_UP ? hi_wmask(JL) : lo_wmask(LG);
    localparam logic [31:0] AT = IS_UP ? 32'h0 :
      attr_bits(BAR_IO[i], BAR_64[i], BAR_PF[i]);

    bar_word_reg #(
      .ACTIVE (ACT || UP_ACT),
      .WMASK  (WM),
      .ATTR   (AT)
    ) u_word (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we && (cfg_idx == IW'(i))),
      .wdata (cfg_wdata),
      .q     (word_q[i]),
      .rd    (word_rd[i])
    );

    assign bar_illegal[i] = BAD;
    assign act_v[i]       = ACT;
    assign up_v[i]        = IS_UP;

    if (ACT) begin : g_dec
      logic [31:0] hi_word;
      if (BAR_64[i] && !BAR_IO[i] && (i < N_BAR - 1)) begin : g_pair
        assign hi_word = word_q[KI];
      end else begin : g_single
        assign hi_word = '0;
      end

      bar_match #(
        .IS_IO (BAR_IO[i]),
        .LG    (LG)
      ) u_match (
        .base_lo   (word_q[i]),
        .base_hi   (hi_word),
        .addr      (addr_eff),
        .req_is_io (req_is_io),
        .mem_en    (mem_en),
        .io_en     (io_en),
        .match     (match_v[i])
      );
    end else begin : g_nodec
      assign match_v[i] = 1'b0;
    end
  end

  bar_prio #(.N(N_BAR)) u_prio (
    .req (match_v),
    .any (any_m),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_bar   <= '0;
      cfg_rdata <= '0;
    end else begin
      hit_valid <= req_valid;
      hit       <= req_valid && any_m;
      hit_bar   <= (req_valid && any_m) ? win_idx : '0;
      if (cfg_rd) begin
        cfg_rdata <= (int'(cfg_idx) < N_BAR) ? word_rd[cfg_idx] : '0;
      end
    end
  end

  // Mask of indices below the reported winner
  logic [N_BAR-1:0] below_win;
  always_comb below_win = (N_BAR'(1) << hit_bar) - N_BAR'(1);

  // R12: a result only follows a request
  a_r12_hit_after_req: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> $past(req_valid));

  // R6: only an active lower BAR can claim a request
  a_r6_active_claim: assert property (@(posedge clk) disable iff (rst)
    hit |-> act_v[hit_bar]);

  // R2: an upper word never claims by itself
  a_r2_no_upper_hit: assert property (@(posedge clk) disable iff (rst)
    hit |-> !up_v[hit_bar]);

  // R9: space type of the winner equals the request's
  a_r9_space_match: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(req_is_io) == BAR_IO[hit_bar]));

  // R10: the matching space enable was set
  a_r10_space_enable: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(req_is_io) ? $past(io_en) : $past(mem_en)));

  // R11: no lower index also matched
  a_r11_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (($past(match_v) & below_win) == '0));

endmodule

// File: tb/sim_bar_hit_decoder.sv
module sim_bar_hit_decoder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, mem_en, io_en, cfg_we, cfg_rd, req_valid, req_is_io, req_is64;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [63:0] req_addr;

  logic        hv [2];
  logic        ht [2];
  logic [2:0]  hb [2];
  logic [31:0] rdt[2];
  logic [5:0]  ill[2];

  bar_hit_decoder #(.LEGACY(1'b0)) u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .io_en(io_en),
    .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdt[0]), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is64(req_is64), .hit_valid(hv[0]), .hit(ht[0]),
    .hit_bar(hb[0]), .bar_illegal(ill[0]));

  bar_hit_decoder #(.LEGACY(1'b1)) u1 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .io_en(io_en),
    .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdt[1]), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_is64(req_is64), .hit_valid(hv[1]), .hit(ht[1]),
    .hit_bar(hb[1]), .bar_illegal(ill[1]));

  int total = 0;
  int bad   = 0;

  // Model of the BAR shapes, written from the requirements
  int lg [6] = '{20, 0, 12, 4, 4, 7};
  bit mio[6] = '{0, 0, 0, 0, 1, 0};
  bit m64[6] = '{1, 0, 0, 0, 0, 0};
  bit mpf[6] = '{1, 0, 1, 0, 0, 1};
  bit act[2][6];
  bit upa[2][6];
  logic [31:0] mw[2][6];

  logic        e_hv [2];
  logic        e_ht [2];
  logic [2:0]  e_hb [2];
  logic [31:0] e_rd [2];

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] wmask(int n, int i);
    int l;
    if (upa[n][i]) begin
      l = lg[i-1];
      return (l <= 32) ? 32'hFFFF_FFFF : ~((32'd1 << (l - 32)) - 32'd1);
    end
    if (act[n][i]) begin
      l = lg[i];
      return (l >= 32) ? 32'h0 : ~((32'd1 << l) - 32'd1);
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] rdval(int n, int i);
    if (upa[n][i]) return mw[n][i];
    if (!act[n][i]) return 32'h0;
    if (mio[i]) return mw[n][i] | 32'h1;
    return mw[n][i] | (32'(mpf[i]) << 3) | (32'(m64[i]) << 2);
  endfunction

  function automatic int model_match(int n);
    logic [63:0] a;
    a = req_is64 ? req_addr : {32'd0, req_addr[31:0]};
    for (int i = 0; i < 6; i++) begin
      if (act[n][i]) begin
        logic [63:0] mask;
        logic [63:0] base;
        bit sp;
        sp   = mio[i] ? (req_is_io && io_en) : (!req_is_io && mem_en);
        mask = ~((64'd1 << lg[i]) - 64'd1);
        base = {(m64[i] && i < 5) ? mw[n][i+1] : 32'h0, mw[n][i]};
        if (sp && ((a & mask) == base)) return i;
      end
    end
    return -1;
  endfunction

  task automatic tick(string tag);
    for (int n = 0; n < 2; n++) begin
      int m;
      m = model_match(n);
      e_hv[n] = req_valid;
      e_ht[n] = req_valid && (m >= 0);
      e_hb[n] = e_ht[n] ? 3'(m) : 3'd0;
      if (cfg_rd) e_rd[n] = (cfg_idx < 6) ? rdval(n, int'(cfg_idx)) : 32'h0;
    end
    if (cfg_we && cfg_idx < 6) begin
      for (int n = 0; n < 2; n++) mw[n][cfg_idx] = cfg_wdata & wmask(n, int'(cfg_idx));
    end
    @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      chk(tag, $sformatf("u%0d hit_valid", n), 64'(hv[n]), 64'(e_hv[n]));
      chk(tag, $sformatf("u%0d hit", n), 64'(ht[n]), 64'(e_ht[n]));
      chk(tag, $sformatf("u%0d hit_bar", n), 64'(hb[n]), 64'(e_hb[n]));
      chk(tag, $sformatf("u%0d cfg_rdata", n), 64'(rdt[n]), 64'(e_rd[n]));
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_rd = 0; req_valid = 0;
  endtask

  task automatic wr(int idx, logic [31:0] d, string tag);
    idle(); cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = d;
    tick(tag);
  endtask

  task automatic rd(int idx, string tag);
    idle(); cfg_rd = 1; cfg_idx = 3'(idx);
    tick(tag);
  endtask

  task automatic req(logic [63:0] a, bit io, bit w64, string tag);
    idle(); req_valid = 1; req_addr = a; req_is_io = io; req_is64 = w64;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    act[0] = '{1, 0, 0, 0, 0, 1};
    act[1] = '{1, 0, 1, 1, 1, 1};
    upa[0] = '{0, 1, 0, 0, 0, 0};
    upa[1] = '{0, 1, 0, 0, 0, 0};
    for (int n = 0; n < 2; n++) begin
      e_hv[n] = 0; e_ht[n] = 0; e_hb[n] = 0; e_rd[n] = 0;
      for (int i = 0; i < 6; i++) mw[n][i] = 32'h0;
    end
    rst = 1; mem_en = 1; io_en = 1; cfg_idx = 0; cfg_wdata = 0;
    req_addr = 0; req_is_io = 0; req_is64 = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int n = 0; n < 2; n++) begin
      chk("R1", "reset hit_valid", 64'(hv[n]), 64'd0);
      chk("R1", "reset hit", 64'(ht[n]), 64'd0);
      chk("R1", "reset hit_bar", 64'(hb[n]), 64'd0);
      chk("R1", "reset cfg_rdata", 64'(rdt[n]), 64'd0);
    end
    for (int i = 0; i < 6; i++) rd(i, "R1");

    // legality flags
    chk("R3", "u0 io bar flag", 64'(ill[0][4]), 64'd1);
    chk("R4", "u0 16B mem flag", 64'(ill[0][3]), 64'd1);
    chk("R5", "u0 pf32 bar2 flag", 64'(ill[0][2]), 64'd1);
    chk("R5", "u0 pf32 bar5 flag", 64'(ill[0][5]), 64'd0);
    chk("R6", "u0 flags", 64'(ill[0]), 64'h1C);
    chk("R3", "u1 flags", 64'(ill[1]), 64'h00);

    // sizing probe
    for (int i = 0; i < 6; i++) wr(i, 32'hFFFF_FFFF, "R7");
    for (int i = 0; i < 6; i++) rd(i, "R7");
    rd(0, "R7");
    chk("R7", "u0 bar0 probe", 64'(rdt[0]), 64'hFFF0_000C);
    rd(1, "R2");
    chk("R2", "u0 bar1 upper probe", 64'(rdt[0]), 64'hFFFF_FFFF);
    rd(4, "R7");
    chk("R7", "u1 io probe", 64'(rdt[1]), 64'hFFFF_FFF1);
    chk("R6", "u0 io probe", 64'(rdt[0]), 64'h0);
    rd(5, "R7");
    chk("R7", "u0 bar5 probe", 64'(rdt[0]), 64'hFFFF_FF88);
    rd(7, "R12");

    // program bases
    wr(0, 32'h1230_0000, "R2");
    wr(1, 32'h0000_0002, "R2");
    wr(2, 32'h4000_0000, "R6");
    wr(3, 32'h4000_0010, "R11");
    wr(4, 32'h0000_1000, "R9");
    wr(5, 32'h8000_0080, "R8");
    for (int i = 0; i < 6; i++) rd(i, "R6");
    rd(2, "R6");
    chk("R6", "u0 bar2 after write", 64'(rdt[0]), 64'h0);

    // decoding
    req(64'h2_1234_5678, 0, 1, "R2");
    chk("R2", "u0 64-bit hit bar", 64'(hb[0]), 64'd0);
    req(64'h0_1234_5678, 0, 1, "R8");
    req(64'h2_1330_0000, 0, 1, "R8");
    req(64'h0000_0002_0000_0000, 0, 1, "R2");
    req(64'h4000_0014, 0, 0, "R11");
    chk("R11", "u1 overlap winner", 64'(hb[1]), 64'd2);
    req(64'h4000_001F, 0, 0, "R11");
    req(64'h8000_00FF, 0, 0, "R8");
    req(64'h8000_0100, 0, 0, "R8");
    req(64'h2_8000_0080, 0, 0, "R8");
    chk("R8", "u0 32-bit width hit", 64'(ht[0]), 64'd1);
    req(64'h2_8000_0080, 0, 1, "R8");
    req(64'h1004, 1, 0, "R9");
    chk("R9", "u1 io hit bar", 64'(hb[1]), 64'd4);
    req(64'h1004, 0, 0, "R9");
    req(64'h4000_0014, 1, 0, "R9");
    mem_en = 0;
    req(64'h8000_0080, 0, 0, "R10");
    chk("R10", "u0 mem disabled", 64'(ht[0]), 64'd0);
    req(64'h100C, 1, 0, "R10");
    mem_en = 1; io_en = 0;
    req(64'h100C, 1, 0, "R10");
    req(64'h8000_0080, 0, 0, "R10");
    io_en = 1;

    // decode and rewrite in the same cycle: old base used
    idle(); req_valid = 1; req_addr = 64'h8000_0080; req_is_io = 0; req_is64 = 0;
    cfg_we = 1; cfg_idx = 3'd5; cfg_wdata = 32'h9000_0000;
    tick("R12");
    req(64'h8000_0080, 0, 0, "R12");
    req(64'h9000_0040, 0, 0, "R12");
    idle();
    tick("R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule